// File: doc/BRIEF.md
# Iterative Crossbar Matching Scheduler

This block schedules an N-by-N input-queued crossbar in which every input holds one virtual queue per output, so a stalled cell for one output never holds back cells for the others. At the start of each timeslot it samples a request matrix in which bit `i*N+j` is set when input `i` has at least one cell waiting for output `j`. It then builds a conflict-free pairing of inputs and outputs over a fixed number of request, grant and accept rounds, one round per clock cycle.

In a round every still-free output grants one of the still-free inputs requesting it. It picks the first requester at or after its grant pointer, in cyclic order. Each input that received grants accepts the first granting output at or after its accept pointer. Pairs accepted in a round are kept, and the inputs and outputs involved drop out of later rounds. Pointers move only on pairs accepted in the first round, which keeps every requester from starving. When the last round ends, the pairing is frozen onto the configuration port and flagged by a one-cycle strobe.

Top module: `xbar_isched`

## Requirements
- R1: While reset is active and after its release, `cfg_valid` is 0, `cfg_mtx` is all zero and every grant and accept pointer is 0.
- R2: A set bit `i*N+j` of `cfg_mtx` implies that bit `i*N+j` of the request matrix sampled for that timeslot was set.
- R3: In `cfg_mtx` every row (input) and every column (output) has at most one set bit.
- R4: In each round, every unpaired output grants the first requesting unpaired input found by scanning upward from its grant pointer, wrapping from N-1 to 0.
- R5: In each round, every unpaired input that received grants accepts the first granting output found by scanning upward from its accept pointer, wrapping from N-1 to 0.
- R6: Only in the first round of a timeslot, an output whose grant was accepted sets its grant pointer to the granted input index plus one modulo N, and an input that accepted sets its accept pointer to the accepted output index plus one modulo N; no other event changes a pointer.
- R7: Pairs made in a round are kept for the timeslot, and inputs and outputs already paired neither request nor grant in later rounds.
- R8: A `slot_start` sampled while idle produces `cfg_valid` high for exactly one cycle, ITERS clock edges after the sampling edge; `cfg_mtx` then holds until the next result.
- R9: A `slot_start` sampled while rounds are in progress is ignored and does not alter the running timeslot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | Begin a timeslot; samples `req_mtx` |
| req_mtx | input | N*N | Request matrix, bit `i*N+j` = input i has a cell for output j |
| cfg_valid | output | 1 | One-cycle strobe: new crossbar configuration |
| cfg_mtx | output | N*N | Configuration, bit `i*N+j` = connect input i to output j |

## Verification
The request matrix is sampled on the edge that sees `slot_start`, the rounds run on the following ITERS edges, and the result with its strobe appears right after the last of them; the bench drives on falling edges and samples exactly one falling edge after that last round edge. One cycle later it checks that the strobe has dropped and the configuration has held, and one cycle before the due edge it checks that no strobe has appeared early. A bench-side model with its own pointer state predicts every result, so pointer moves from earlier timeslots (R6) are checked through the pairings chosen later.

// File: rtl/xbar_isched_pkg.sv
package xbar_isched_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } sched_phase_t;
endpackage

// File: rtl/xbar_rr_pick.sv
// Round-robin selector: first set bit at or after ptr, cyclic.
module xbar_rr_pick #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [N-1:0] pick
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx] && !found) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_rr_ptr.sv
// Round-robin pointer register with explicit update enable.
module xbar_rr_ptr #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (upd) ptr_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R6: pointer moves only when its update enable is set
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ptr));
  // R6: pointer always names a valid port
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < N);
endmodule

// File: rtl/xbar_isched.sv
module xbar_isched
  import xbar_isched_pkg::*;
#(
  parameter int N     = 4,
  parameter int ITERS = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_start,
  input  logic [N*N-1:0] req_mtx,
  output logic           cfg_valid,
  output logic [N*N-1:0] cfg_mtx
);
  localparam int W  = (N > 1) ? $clog2(N) : 1;
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam int NN = N * N;

  sched_phase_t   phase_q, phase_d;
  logic [CW-1:0]  iter_q, iter_d;
  logic [NN-1:0]  req_q;
  logic [NN-1:0]  work_q, work_d;
  logic [N-1:0]   in_m_q, in_m_d, out_m_q, out_m_d;
  logic [NN-1:0]  cfg_d;
  logic           cfg_valid_d;
  logic           cap_en, run, last_iter, first_iter, cfg_en;

  logic [N-1:0]   elig [N];   // per output: eligible inputs
  logic [N-1:0]   gnt  [N];   // per output: granted input
  logic [N-1:0]   gin  [N];   // per input: grants received
  logic [N-1:0]   acc  [N];   // per input: accepted output
  logic [NN-1:0]  acc_flat;
  logic [W-1:0]   gptr [N], aptr [N];
  logic [W-1:0]   g_nxt [N], a_nxt [N];
  logic [N-1:0]   g_hit, a_hit;

  assign run        = (phase_q == PH_RUN);
  assign cap_en     = (phase_q == PH_IDLE) && slot_start;
  assign last_iter  = run && (iter_q == CW'(ITERS - 1));
  assign first_iter = run && (iter_q == '0);
  assign cfg_en     = last_iter;

  // request / grant matrices seen from both sides
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) begin
        elig[j][i]       = req_q[i*N+j] & ~in_m_q[i] & ~out_m_q[j];
        gin[i][j]        = gnt[j][i];
        acc_flat[i*N+j]  = acc[i][j];
      end
  end

  genvar gj;
  generate
    for (gj = 0; gj < N; gj++) begin : g_port
      xbar_rr_pick #(.N(N), .W(W)) u_grant (
        .req(elig[gj]), .ptr(gptr[gj]), .pick(gnt[gj]));
      xbar_rr_pick #(.N(N), .W(W)) u_accept (
        .req(gin[gj]), .ptr(aptr[gj]), .pick(acc[gj]));
      xbar_rr_ptr #(.N(N), .W(W)) u_gptr (
        .clk(clk), .rst_n(rst_n), .upd(first_iter && g_hit[gj]),
        .nxt(g_nxt[gj]), .ptr(gptr[gj]));
      xbar_rr_ptr #(.N(N), .W(W)) u_aptr (
        .clk(clk), .rst_n(rst_n), .upd(first_iter && a_hit[gj]),
        .nxt(a_nxt[gj]), .ptr(aptr[gj]));
    end
  endgenerate

  // pointer targets: one past the accepted partner
  always_comb begin
    for (int p = 0; p < N; p++) begin
      g_hit[p] = 1'b0;
      a_hit[p] = 1'b0;
      g_nxt[p] = '0;
      a_nxt[p] = '0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (acc[i][j]) begin
          g_hit[j] = 1'b1;
          g_nxt[j] = (i == N - 1) ? '0 : W'(i + 1);
          a_hit[i] = 1'b1;
          a_nxt[i] = (j == N - 1) ? '0 : W'(j + 1);
        end
  end

  // next-state
  always_comb begin
    phase_d     = phase_q;
    iter_d      = iter_q;
    work_d      = work_q;
    in_m_d      = in_m_q;
    out_m_d     = out_m_q;
    cfg_d       = work_q | acc_flat;
    cfg_valid_d = 1'b0;
    if (cap_en) begin
      phase_d = PH_RUN;
      iter_d  = '0;
      work_d  = '0;
      in_m_d  = '0;
      out_m_d = '0;
    end else if (run) begin
      work_d = work_q | acc_flat;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (acc[i][j]) begin
            in_m_d[i]  = 1'b1;
            out_m_d[j] = 1'b1;
          end
      if (last_iter) begin
        phase_d     = PH_IDLE;
        cfg_valid_d = 1'b1;
      end else begin
        iter_d = iter_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      iter_q    <= '0;
      work_q    <= '0;
      in_m_q    <= '0;
      out_m_q   <= '0;
      cfg_valid <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      iter_q    <= iter_d;
      work_q    <= work_d;
      in_m_q    <= in_m_d;
      out_m_q   <= out_m_d;
      cfg_valid <= cfg_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (cap_en) req_q <= req_mtx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_mtx <= '0;
    else if (cfg_en) cfg_mtx <= cfg_d;
  end

  // R3: rows and columns of the result carry at most one connection
  genvar ga;
  generate
    for (ga = 0; ga < N; ga++) begin : g_chk
      logic [N-1:0] row_v, col_v;
      always_comb
        for (int k = 0; k < N; k++) begin
          row_v[k] = cfg_mtx[ga*N+k];
          col_v[k] = cfg_mtx[k*N+ga];
        end
      assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $onehot0(row_v));
      assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $onehot0(col_v));
    end
  endgenerate

  // R2: every connection was requested
  assert_only_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ((cfg_mtx & ~req_q) == '0));
  // R8: strobe lasts one cycle
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !cfg_valid);
  // R9: sampled requests frozen while rounds run
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(req_q));
  // R7: paired inputs stay paired until the timeslot ends
  assert_pairs_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_iter) |=> ((in_m_q & $past(in_m_q)) == $past(in_m_q)));
endmodule

// File: tb/xbar_isched_tb.sv
`timescale 1ns/1ps
module xbar_isched_tb_top;
  localparam int N  = 4;
  localparam int IT = 2;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slot_start;
  logic [NN-1:0] req_mtx;
  logic          cfg_valid;
  logic [NN-1:0] cfg_mtx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int gp [N];
  int ap [N];

  always #10 clk = ~clk;

  xbar_isched #(.N(N), .ITERS(IT)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .req_mtx(req_mtx), .cfg_valid(cfg_valid), .cfg_mtx(cfg_mtx));

  task automatic chk(input bit ok, input string tag,
                     input logic [NN-1:0] act, input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: rounds of grant/accept with model pointers
  function automatic logic [NN-1:0] predict(input logic [NN-1:0] r);
    logic [NN-1:0] m;
    bit im [N];
    bit om [N];
    int gsrc [N];
    m = '0;
    for (int p = 0; p < N; p++) begin im[p] = 0; om[p] = 0; end
    for (int it = 0; it < IT; it++) begin
      for (int j = 0; j < N; j++) begin
        gsrc[j] = -1;
        for (int k = 0; k < N; k++) begin
          int i;
          i = (gp[j] + k) % N;
          if (gsrc[j] < 0 && r[i*N+j] && !im[i] && !om[j]) gsrc[j] = i;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (!im[i]) begin
          int pickj;
          pickj = -1;
          for (int k = 0; k < N; k++) begin
            int j;
            j = (ap[i] + k) % N;
            if (pickj < 0 && gsrc[j] == i) pickj = j;
          end
          if (pickj >= 0) begin
            m[i*N+pickj] = 1'b1;
            im[i] = 1;
            om[pickj] = 1;
            if (it == 0) begin
              gp[pickj] = (i + 1) % N;
              ap[i] = (pickj + 1) % N;
            end
          end
        end
      end
    end
    return m;
  endfunction

  task automatic run_slot(input logic [NN-1:0] r, input bit disturb);
    logic [NN-1:0] exp;
    logic [NN-1:0] held;
    bit ok;
    exp = predict(r);
    @(negedge clk);
    slot_start = 1'b1;
    req_mtx = r;
    @(negedge clk);                   // sampling edge passed
    slot_start = disturb;             // R9: start while busy
    req_mtx = disturb ? ~r : r;
    for (int e = 0; e < IT; e++) begin
      if (e == IT - 1)
        chk(cfg_valid == 1'b0, "R8 strobe early", {15'd0, cfg_valid}, '0);
      @(negedge clk);
      slot_start = 1'b0;
      req_mtx = r;
    end
    chk(cfg_valid == 1'b1, "R8 strobe missing", {15'd0, cfg_valid}, 1);
    chk(cfg_mtx == exp, "R4 R5 R6 R7 R9 pairing", cfg_mtx, exp);
    chk((cfg_mtx & ~r) == '0, "R2 unrequested pair", cfg_mtx, cfg_mtx & r);
    ok = 1;
    for (int a = 0; a < N; a++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int b = 0; b < N; b++) begin
        rc += cfg_mtx[a*N+b];
        cc += cfg_mtx[b*N+a];
      end
      if (rc > 1 || cc > 1) ok = 0;
    end
    chk(ok, "R3 crossbar conflict", cfg_mtx, exp);
    held = cfg_mtx;
    @(negedge clk);
    chk(cfg_valid == 1'b0, "R8 strobe too long", {15'd0, cfg_valid}, '0);
    chk(cfg_mtx == held, "R8 result not held", cfg_mtx, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int p = 0; p < N; p++) begin gp[p] = 0; ap[p] = 0; end
    rst_n = 1'b0;
    slot_start = 1'b0;
    req_mtx = '0;
    repeat (3) @(negedge clk);
    chk(cfg_valid == 1'b0, "R1 reset strobe", {15'd0, cfg_valid}, '0);
    chk(cfg_mtx == '0, "R1 reset config", cfg_mtx, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_valid == 1'b0 && cfg_mtx == '0, "R1 after release", cfg_mtx, '0);

    run_slot('0, 0);                             // no requests
    for (int t = 0; t < 6; t++) run_slot('1, 0); // full load: R6 rotation
    run_slot(16'h8421, 0);                       // diagonal
    run_slot(16'h000F, 0);                       // all from input 0
    run_slot(16'h1111, 0);                       // all to output 0
    run_slot(16'h00F0, 1);                       // R9 disturbance
    run_slot('1, 1);
    lf = 16'hACE1;
    for (int t = 0; t < 250; t++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_slot(lf, (t % 7) == 3);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule